// File: doc/BRIEF.md
# Atomic Acquire/Release Ordering Gate

This block sits between an in-order request issue stage and the memory system. It applies the ordering that an atomic operation's acquire and release bits call for. Each request carries its kind (ordinary access or atomic), the acquire bit, the release bit and a domain bit that picks main memory or I/O. The gate counts the requests in flight in each domain: it adds one on each issue handshake and subtracts one on each completion pulse. It holds a request back until the rules for that request's domain are met.

The ordering applies only inside the domain that the atomic targets. Traffic to the other domain never waits on it. Requests flow through without a register stage. A stall removes valid toward memory and ready toward the issue stage in the same cycle. The block has no fence support, no cache and no atomic arithmetic, and it does not order one domain against the other.

Top module: `amo_order_gate`

## Requirements
- R1: An atomic with both acquire and release bits clear passes in the same cycle it is presented, even while same-domain requests are in flight.
- R2: Once an atomic with the acquire bit set has been accepted, no further request to its domain is accepted until that domain's in-flight count has returned to zero. Acceptance resumes in the cycle after the completion that emptied the count.
- R3: An atomic with the release bit set is held while its domain's in-flight count, as registered at the start of the cycle, is nonzero. It passes in the first cycle that begins with the count at zero.
- R4: An atomic with both bits set waits as in R3 and, once accepted, blocks its domain as in R2.
- R5: Domain bit 0 is main memory and 1 is I/O. A request to one domain is never held because of the in-flight count or the acquire block of the other domain.
- R6: Each domain's in-flight count rises by one per accepted request and falls by one per completion tagged with that domain. When both happen in one cycle the count is unchanged. Ordinary accesses are not held by a nonzero count.
- R7: A request is held while its domain already has MAX_OUT requests in flight. It is accepted in the cycle after a completion to that domain.
- R8: A completion to a domain whose count is zero raises err_o for exactly the following cycle, and the count stays at zero.
- R9: mem_valid_o is req_valid_i with any stall removed, and req_ready_o is mem_ready_i with any stall removed. The request fields reach the memory side unchanged. While stalled, both mem_valid_o and req_ready_o are low.
- R10: After reset both counts are zero, no domain is blocked, err_o is low, and an idle gate shows req_ready_o high and mem_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present from issue stage |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_atomic_i | input | 1 | Request is an atomic operation |
| req_aq_i | input | 1 | Acquire bit |
| req_rl_i | input | 1 | Release bit |
| req_dom_i | input | 1 | Domain: 0 main memory, 1 I/O |
| req_addr_i | input | AW | Request address |
| mem_valid_o | output | 1 | Request toward memory |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_atomic_o | output | 1 | Forwarded atomic flag |
| mem_aq_o | output | 1 | Forwarded acquire bit |
| mem_rl_o | output | 1 | Forwarded release bit |
| mem_dom_o | output | 1 | Forwarded domain |
| mem_addr_o | output | AW | Forwarded address |
| cpl_valid_i | input | 1 | One request has completed |
| cpl_dom_i | input | 1 | Domain of the completed request |
| err_o | output | 1 | Completion seen with nothing in flight |

## Verification
The hardest cases to reach from the ports are the cycles where a count changes while a request is held. Examples are a completion that lands in the same cycle as an issue, and the single completion that releases a waiting release-atomic or clears an acquire block. The stimulus holds one request valid and sends completions one per cycle. It samples ready in each of those cycles, so a count that is off by one, or a release that comes one cycle early or late, shows up as a ready value in the wrong cycle. To check that the domains stay separate, an I/O request is sent while main memory is blocked, and a release atomic to I/O is sent while main memory has work in flight.

// File: rtl/amo_gate_pkg.sv
package amo_gate_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // Domain selector carried on every request and completion
    typedef enum logic {
        DOM_MEM = 1'b0,
        DOM_IO  = 1'b1
    } dom_e;

    localparam int unsigned NDOM = 2;
endpackage

// File: rtl/amo_dom_track.sv
module amo_dom_track #(
    parameter  int unsigned MAX_OUT = 8,
    localparam int unsigned CW      = $clog2(MAX_OUT + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          issue_i,
    input  logic          cpl_i,
    input  logic          acq_i,
    output logic [CW-1:0] cnt_o,
    output logic          blk_o,
    output logic          full_o,
    output logic          uflow_o
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          blk;
        logic          uflow;
    } trk_t;

    trk_t st_d, st_q;
    logic dec;

    always_comb begin
        st_d       = st_q;
        dec        = cpl_i && (st_q.cnt != '0);
        st_d.uflow = cpl_i && (st_q.cnt == '0);
        st_d.cnt   = st_q.cnt + CW'(issue_i) - CW'(dec);
        if (issue_i && acq_i) begin
            st_d.blk = 1'b1;
        end else if (st_d.cnt == '0) begin
            st_d.blk = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign blk_o   = st_q.blk;
    assign full_o  = (st_q.cnt == CW'(MAX_OUT));
    assign uflow_o = st_q.uflow;
endmodule

// File: rtl/amo_issue_rule.sv
module amo_issue_rule
    import amo_gate_pkg::*;
#(
    parameter int unsigned CW = 4
) (
    input  logic                 atomic_i,
    input  logic                 rl_i,
    input  dom_e                 dom_i,
    input  logic [NDOM-1:0][CW-1:0] cnt_i,
    input  logic [NDOM-1:0]      blk_i,
    input  logic [NDOM-1:0]      full_i,
    output logic                 stall_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic busy;
    logic rel_wait;

    always_comb begin
        busy     = (cnt_i[dom_i] != '0);
        rel_wait = atomic_i && rl_i && busy;
        stall_o  = blk_i[dom_i] || full_i[dom_i] || rel_wait;
    end
endmodule

// File: rtl/amo_order_gate.sv
module amo_order_gate
    import amo_gate_pkg::*;
#(
    parameter  int unsigned AW      = 32,
    parameter  int unsigned MAX_OUT = 8,
    localparam int unsigned CW      = $clog2(MAX_OUT + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic          req_atomic_i,
    input  logic          req_aq_i,
    input  logic          req_rl_i,
    input  logic          req_dom_i,
    input  logic [AW-1:0] req_addr_i,
    output logic          mem_valid_o,
    input  logic          mem_ready_i,
    output logic          mem_atomic_o,
    output logic          mem_aq_o,
    output logic          mem_rl_o,
    output logic          mem_dom_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          cpl_valid_i,
    input  logic          cpl_dom_i,
    output logic          err_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [NDOM-1:0][CW-1:0] cnt_w;
    logic [NDOM-1:0]         blk_w;
    logic [NDOM-1:0]         full_w;
    logic [NDOM-1:0]         uflow_w;
    logic                    stall;
    logic                    issue_hs;

    amo_issue_rule #(.CW(CW)) u_rule (
        .atomic_i (req_atomic_i),
        .rl_i     (req_rl_i),
        .dom_i    (dom_e'(req_dom_i)),
        .cnt_i    (cnt_w),
        .blk_i    (blk_w),
        .full_i   (full_w),
        .stall_o  (stall)
    );

    assign mem_valid_o  = req_valid_i && !stall;
    assign req_ready_o  = mem_ready_i && !stall;
    assign issue_hs     = mem_valid_o && mem_ready_i;
    assign mem_atomic_o = req_atomic_i;
    assign mem_aq_o     = req_aq_i;
    assign mem_rl_o     = req_rl_i;
    assign mem_dom_o    = req_dom_i;
    assign mem_addr_o   = req_addr_i;

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        amo_dom_track #(.MAX_OUT(MAX_OUT)) u_trk (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .issue_i (issue_hs && (req_dom_i == 1'(d))),
            .cpl_i   (cpl_valid_i && (cpl_dom_i == 1'(d))),
            .acq_i   (req_atomic_i && req_aq_i),
            .cnt_o   (cnt_w[d]),
            .blk_o   (blk_w[d]),
            .full_o  (full_w[d]),
            .uflow_o (uflow_w[d])
        );
    end

    assign err_o = |uflow_w;
endmodule

// File: rtl/amo_order_gate_chk.sv
module amo_order_gate_chk #(
    parameter int unsigned NDOM    = 2,
    parameter int unsigned CW      = 4,
    parameter int unsigned MAX_OUT = 8
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    req_valid_i,
    input logic                    req_ready_o,
    input logic                    req_atomic_i,
    input logic                    req_aq_i,
    input logic                    req_rl_i,
    input logic                    req_dom_i,
    input logic                    mem_valid_o,
    input logic                    mem_ready_i,
    input logic                    cpl_valid_i,
    input logic                    cpl_dom_i,
    input logic                    err_o,
    input logic [NDOM-1:0][CW-1:0] cnt_w,
    input logic [NDOM-1:0]         blk_w
);
    timeunit 1ns;
    timeprecision 100ps;

    logic hs;
    assign hs = mem_valid_o && mem_ready_i;

    AST_ACQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_w[req_dom_i] |-> !hs); // R2

    AST_REL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs && req_atomic_i && req_rl_i) |-> (cnt_w[req_dom_i] == '0)); // R3

    AST_SC_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs && req_atomic_i && req_aq_i && req_rl_i) |=> blk_w[$past(req_dom_i)]); // R4

    AST_OTHER_DOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && mem_ready_i && !blk_w[req_dom_i] && (cnt_w[req_dom_i] == '0))
            |-> req_ready_o); // R5

    AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpl_valid_i && (cnt_w[cpl_dom_i] == '0)) |=> err_o); // R8

    AST_READY_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |-> (mem_valid_o && mem_ready_i)); // R9

    for (genvar d = 0; d < NDOM; d++) begin : g_chk
        AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) |-> (int'(cnt_w[d]) == int'($past(cnt_w[d]))
                + int'($past(hs && (req_dom_i == 1'(d))))
                - int'($past(cpl_valid_i && (cpl_dom_i == 1'(d)) && (cnt_w[d] != '0))))); // R6

        AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            int'(cnt_w[d]) <= int'(MAX_OUT)); // R7
    end
endmodule

bind amo_order_gate amo_order_gate_chk #(
    .NDOM    (NDOM),
    .CW      (CW),
    .MAX_OUT (MAX_OUT)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_atomic_i (req_atomic_i),
    .req_aq_i     (req_aq_i),
    .req_rl_i     (req_rl_i),
    .req_dom_i    (req_dom_i),
    .mem_valid_o  (mem_valid_o),
    .mem_ready_i  (mem_ready_i),
    .cpl_valid_i  (cpl_valid_i),
    .cpl_dom_i    (cpl_dom_i),
    .err_o        (err_o),
    .cnt_w        (cnt_w),
    .blk_w        (blk_w)
);

// File: tb/sim_amo_order_gate.sv
module sim_amo_order_gate;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned AW = 32;
    localparam int unsigned MO = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_atomic = 1'b0, req_aq = 1'b0, req_rl = 1'b0, req_dom = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          mem_valid, mem_atomic, mem_aq, mem_rl, mem_dom;
    logic [AW-1:0] mem_addr;
    logic          mem_ready = 1'b1;
    logic          cpl_valid = 1'b0, cpl_dom = 1'b0;
    logic          err;

    int vec_cnt = 0;
    int bad_cnt = 0;
    bit done = 1'b0;
    logic [AW+3:0] exp_q[$];

    always #2 clk = ~clk; // 4 ns period, 250 MHz

    amo_order_gate #(.AW(AW), .MAX_OUT(MO)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_atomic_i(req_atomic), .req_aq_i(req_aq), .req_rl_i(req_rl),
        .req_dom_i(req_dom), .req_addr_i(req_addr),
        .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
        .mem_atomic_o(mem_atomic), .mem_aq_o(mem_aq), .mem_rl_o(mem_rl),
        .mem_dom_o(mem_dom), .mem_addr_o(mem_addr),
        .cpl_valid_i(cpl_valid), .cpl_dom_i(cpl_dom), .err_o(err)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        vec_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s act=%0h exp=%0h @%0t", rq, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    // Driver: present a request and record what memory must see
    task automatic put(input bit a, input bit aq, input bit rl, input bit d, input logic [AW-1:0] ad);
        req_valid  = 1'b1;
        req_atomic = a;
        req_aq     = aq;
        req_rl     = rl;
        req_dom    = d;
        req_addr   = ad;
        exp_q.push_back({a, aq, rl, d, ad});
    endtask

    task automatic drop();
        req_valid = 1'b0;
    endtask

    task automatic cpl(input bit d);
        cpl_valid = 1'b1;
        cpl_dom   = d;
    endtask

    task automatic rdy(input logic e, input string rq);
        #1;
        chk(req_ready === e, rq, longint'(req_ready), longint'(e));
    endtask

    // Monitor: pops the scoreboard on every memory-side handshake (R9 fields)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && mem_valid && mem_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected issue", longint'(mem_addr), 0);
                end else begin
                    logic [AW+3:0] e;
                    e = exp_q.pop_front();
                    chk({mem_atomic, mem_aq, mem_rl, mem_dom, mem_addr} === e, "R9 fields",
                        longint'({mem_atomic, mem_aq, mem_rl, mem_dom, mem_addr}), longint'(e));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        step(); #1;
        chk(req_ready === 1'b1, "R10 ready", longint'(req_ready), 1);
        chk(mem_valid === 1'b0, "R10 valid", longint'(mem_valid), 0);
        chk(err === 1'b0, "R10 err", longint'(err), 0);

        // R6 plain accesses, then R1 relaxed atomic with traffic in flight
        for (int i = 0; i < 3; i++) begin
            step(); put(0, 0, 0, 0, AW'(32'h10 + i)); rdy(1, "R6 plain");
        end
        step(); put(1, 0, 0, 0, 32'h20); rdy(1, "R1 relaxed atomic");

        // R3 release atomic waits for four completions
        step(); put(1, 0, 1, 0, 32'h21); cpl(0); rdy(0, "R3 held");
        chk(mem_valid === 1'b0, "R9 valid low when held", longint'(mem_valid), 0);
        for (int i = 0; i < 3; i++) begin
            step(); cpl(0); rdy(0, "R3 held");
        end
        step(); rdy(1, "R3 release");
        step(); drop(); cpl(0);

        // R2 acquire atomic blocks main memory; R5 I/O still flows
        step(); put(1, 1, 0, 0, 32'h30); rdy(1, "R2 acquire issue");
        step(); put(0, 0, 0, 1, 32'h40); rdy(1, "R5 io while mem blocked");
        step(); put(0, 0, 0, 0, 32'h31); rdy(0, "R2 blocked");
        step(); cpl(0); rdy(0, "R2 blocked");
        step(); rdy(1, "R2 unblocked");
        step(); drop(); cpl(0);
        step(); cpl(1);

        // R5 release atomic to I/O with memory busy
        step(); put(0, 0, 0, 0, 32'h50); rdy(1, "R5 setup");
        step(); put(1, 0, 1, 1, 32'h51); rdy(1, "R5 io release");
        step(); drop(); cpl(0);
        step(); cpl(1);

        // R4 both bits
        step(); put(0, 0, 0, 0, 32'h60); rdy(1, "R4 setup");
        step(); put(1, 1, 1, 0, 32'h61); rdy(0, "R4 waits");
        step(); cpl(0); rdy(0, "R4 waits");
        step(); rdy(1, "R4 issues");
        step(); put(0, 0, 0, 0, 32'h62); rdy(0, "R4 blocks");
        step(); cpl(0); rdy(0, "R4 blocks");
        step(); rdy(1, "R4 unblocked");
        step(); drop(); cpl(0);

        // R6 issue and completion in one cycle
        step(); put(0, 0, 0, 0, 32'h70); rdy(1, "R6 setup");
        step(); put(0, 0, 0, 0, 32'h71); cpl(0); rdy(1, "R6 same cycle");
        step(); put(1, 0, 1, 0, 32'h72); cpl(0); rdy(0, "R6 count one");
        step(); rdy(1, "R6 count zero");
        step(); drop(); cpl(0);

        // R8 completion with nothing in flight
        step(); cpl(0); #1;
        chk(err === 1'b0, "R8 err not yet", longint'(err), 0);
        step(); #1;
        chk(err === 1'b1, "R8 err pulse", longint'(err), 1);
        step(); #1;
        chk(err === 1'b0, "R8 err one cycle", longint'(err), 0);
        step(); put(1, 0, 1, 0, 32'h80); rdy(1, "R8 count stayed zero");
        step(); drop(); cpl(0);

        // R7 full domain
        for (int i = 0; i < MO; i++) begin
            step(); put(0, 0, 0, 1, AW'(32'h100 + i)); rdy(1, "R7 filling");
        end
        step(); put(0, 0, 0, 1, 32'h108); rdy(0, "R7 full");
        step(); cpl(1); rdy(0, "R7 full");
        step(); rdy(1, "R7 room");
        step(); drop();
        for (int i = 0; i < MO; i++) begin
            step(); cpl(1);
        end

        // R9 memory back-pressure passes through
        step(); mem_ready = 1'b0; put(1, 1, 1, 1, 32'hAB); rdy(0, "R9 ready follows memory");
        chk(mem_valid === 1'b1, "R9 valid passes", longint'(mem_valid), 1);
        chk(mem_addr === 32'hAB, "R9 addr passes", longint'(mem_addr), 32'hAB);
        step(); mem_ready = 1'b1; rdy(1, "R9 accepted");
        step(); drop(); cpl(1);

        repeat (3) step();
        chk(exp_q.size() == 0, "R9 all issued", longint'(exp_q.size()), 0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end
endmodule